// File: doc/BRIEF.md
# ModR/M Effective Address Generator

This unit sits after the opcode stage of an x86-style real-mode decoder. It takes the operand-addressing byte and the bytes that follow it from the instruction byte stream, one byte per handshake. From them it works out the operand offset for a register-indirect memory operand. It also picks the segment that applies and forms the 20-bit physical address. Opcode decode and the memory access itself are handled elsewhere. The unit only consumes the addressing bytes and reports how many it took.

A caller sets the address-size flag, the eight general register values, the six segment register values and the one-hot segment-override prefix state. It then streams bytes on `in_valid`/`in_data`. The unit reads a scale-index-base byte when the form calls for one, then the displacement bytes in little-endian order. After the last byte it raises `done` for one cycle. During that cycle the decoded fields, offset, segment, physical address, byte count and error flag are valid.

Top module: `modrm_ea_unit`

## Requirements
- R1: The first byte splits into mod = bits 7:6, reg = bits 5:3 and rm = bits 2:0, shown on `mod_o`/`reg_o`/`rm_o`. `done` is high for exactly one cycle, in the cycle after the handshake of the last addressing byte, and low at all other times.
- R2: With mod = 3 the operand is a register. `is_mem`=0, `nbytes`=1, `offset`=0, `phys_addr`=0, `err`=0 and `seg_sel`=3, and no further byte is consumed.
- R3: In 16-bit mode rm 0..7 selects BX+SI, BX+DI, BP+SI, BP+DI, SI, DI, BP, BX. The register numbers are AX0 CX1 DX2 BX3 SP4 BP5 SI6 DI7 on `gpr_flat` bits [32*i+31:32*i], and only the low 16 bits are used. mod = 0 with rm = 6 is a bare 16-bit displacement. rm = 4 never reads a SIB byte in this mode.
- R4: In 16-bit mode mod = 1 adds a sign-extended byte displacement and mod = 2 adds a 16-bit displacement. The 16-bit offset wraps modulo 65536, and bits 31:16 of `offset` are 0.
- R5: The default segment is SS (code 2) for 16-bit BP+SI, BP+DI and BP+disp forms. It is also SS for 32-bit forms whose base is EBP with a displacement, or ESP through a SIB byte. Every other form defaults to DS (code 3).
- R6: Segment codes are ES0 CS1 SS2 DS3 FS4 GS5, and bit i of `seg_ovr` requests segment i. A single set bit replaces the default segment in `seg_sel`.
- R7: With more than one override bit set on a memory operand, `err`=1, `phys_addr`=0 and `seg_sel` shows the default segment. With a register operand `err` stays 0.
- R8: In 32-bit mode mod = 0 with rm = 5 is a bare 32-bit displacement. mod = 1 adds a sign-extended byte and mod = 2 adds a 32-bit displacement, both to the register selected by rm.
- R9: In 32-bit mode rm = 4 (mod ≠ 3) reads a SIB byte (scale 7:6, index 5:3, base 2:0). The offset is base + index·2^scale + displacement. Index 4 adds nothing. Base 5 with mod = 0 uses a 32-bit displacement in place of EBP.
- R10: `phys_addr` = (segment value · 16 + offset) modulo 2^20.
- R11: `nbytes` counts every byte consumed, including the first. A byte is taken only when `in_valid` is high. `in_ready` is high except during the `done` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Byte stream valid |
| in_data | input | 8 | Byte stream data |
| in_ready | output | 1 | Unit can take a byte |
| addr32 | input | 1 | 1 = 32-bit address size, sampled with the first byte |
| gpr_flat | input | 256 | Eight 32-bit general registers, register i at bits 32*i+31:32*i |
| seg_flat | input | 96 | Six 16-bit segment registers, code i at bits 16*i+15:16*i |
| seg_ovr | input | 6 | Override request, bit i selects segment code i |
| done | output | 1 | One-cycle result strobe |
| mod_o | output | 2 | Decoded mod field |
| reg_o | output | 3 | Decoded reg field |
| rm_o | output | 3 | Decoded rm field |
| is_mem | output | 1 | 1 = memory operand, 0 = register operand |
| offset | output | 32 | Effective offset |
| seg_sel | output | 3 | Selected segment code |
| phys_addr | output | 20 | Real-mode physical address |
| nbytes | output | 3 | Bytes consumed |
| err | output | 1 | Multiple-override error |

## Verification
Properties are checked on every cycle for the parts that do not depend on the addressing table. These are the one-cycle `done` strobe, the ready drop during it, and the register-operand result. They also cover the override error forcing a zero address, a single override landing in `seg_sel`, and the physical address agreeing with the selected segment value and offset. The base/index table itself, displacement sign extension, 16-bit wrap, the SIB special cases, the SS defaults and the byte counts can only be shown by the bench's scenarios. The bench compares each of those against its behavioural model of the byte stream.

// File: rtl/ea_pkg.sv
package ea_pkg;

    typedef enum logic [2:0] {
        SEG_ES = 3'd0,
        SEG_CS = 3'd1,
        SEG_SS = 3'd2,
        SEG_DS = 3'd3,
        SEG_FS = 3'd4,
        SEG_GS = 3'd5
    } seg_e;

    typedef struct packed {
        logic [1:0] md;
        logic [2:0] rg;
        logic [2:0] rm;
    } modrm_t;

    typedef struct packed {
        logic [1:0] scale;
        logic [2:0] index;
        logic [2:0] base;
    } sib_t;

    typedef enum logic [1:0] {
        ST_MODRM,
        ST_SIB,
        ST_DISP,
        ST_EMIT
    } col_state_e;

    localparam logic [2:0] GR_SP = 3'd4;
    localparam logic [2:0] GR_BP = 3'd5;
    localparam logic [2:0] GR_BX = 3'd3;
    localparam logic [2:0] GR_SI = 3'd6;
    localparam logic [2:0] GR_DI = 3'd7;

    // Number of displacement bytes that follow, given the address form.
    function automatic logic [2:0] disp_bytes(input logic a32, input logic [1:0] md,
                                              input logic [2:0] rm, input logic [2:0] sbase);
        if (md == 2'b11) return 3'd0;
        if (md == 2'b01) return 3'd1;
        if (!a32) return (md == 2'b10 || rm == 3'd6) ? 3'd2 : 3'd0;
        if (md == 2'b10) return 3'd4;
        if (rm == 3'd5) return 3'd4;
        if (rm == 3'd4 && sbase == 3'd5) return 3'd4;
        return 3'd0;
    endfunction

    // Sign-extend the collected displacement according to its length.
    function automatic logic [31:0] sext_disp(input logic [31:0] d, input logic [2:0] len);
        case (len)
            3'd1:    return {{24{d[7]}}, d[7:0]};
            3'd2:    return {{16{d[15]}}, d[15:0]};
            default: return d;
        endcase
    endfunction

endpackage

// File: rtl/ea_collect.sv
module ea_collect
    import ea_pkg::*;
#(
    parameter int DISP_MAX = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    input  logic [7:0]              in_data,
    output logic                    in_ready,
    input  logic                    addr32,
    output logic                    emit,
    output logic                    a32_q,
    output modrm_t                  modrm_q,
    output sib_t                    sib_q,
    output logic                    has_sib_q,
    output logic [2:0]              disp_len_q,
    output logic [8*DISP_MAX-1:0]   disp_q
);
    localparam int IDX_W = $clog2(DISP_MAX);

    col_state_e       state;
    logic [IDX_W-1:0] disp_idx;
    logic [2:0]       disp_left;
    modrm_t           m_in;
    logic             sib_next;
    logic [2:0]       n_first;
    logic [2:0]       n_sib;

    assign m_in     = modrm_t'(in_data);
    assign sib_next = addr32 && (m_in.md != 2'b11) && (m_in.rm == 3'd4);
    assign n_first  = disp_bytes(addr32, m_in.md, m_in.rm, 3'd0);
    assign n_sib    = disp_bytes(a32_q, modrm_q.md, modrm_q.rm, in_data[2:0]);
    assign in_ready = (state != ST_EMIT);
    assign emit     = (state == ST_EMIT);

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_MODRM;
            a32_q      <= 1'b0;
            modrm_q    <= '0;
            sib_q      <= '0;
            has_sib_q  <= 1'b0;
            disp_len_q <= '0;
            disp_q     <= '0;
            disp_idx   <= '0;
            disp_left  <= '0;
        end else begin
            case (state)
                ST_MODRM: if (in_valid) begin
                    modrm_q    <= m_in;
                    a32_q      <= addr32;
                    sib_q      <= '0;
                    disp_q     <= '0;
                    disp_idx   <= '0;
                    has_sib_q  <= sib_next;
                    disp_len_q <= n_first;
                    disp_left  <= n_first;
                    if (m_in.md == 2'b11)  state <= ST_EMIT;
                    else if (sib_next)     state <= ST_SIB;
                    else if (n_first == 0) state <= ST_EMIT;
                    else                   state <= ST_DISP;
                end
                ST_SIB: if (in_valid) begin
                    sib_q      <= sib_t'(in_data);
                    disp_len_q <= n_sib;
                    disp_left  <= n_sib;
                    state      <= (n_sib == 0) ? ST_EMIT : ST_DISP;
                end
                ST_DISP: if (in_valid) begin
                    disp_q[{disp_idx, 3'b000} +: 8] <= in_data;
                    disp_idx  <= disp_idx + 1'b1;
                    disp_left <= disp_left - 3'd1;
                    if (disp_left == 3'd1) state <= ST_EMIT;
                end
                default: state <= ST_MODRM;
            endcase
        end
    end
endmodule

// File: rtl/ea_offset.sv
module ea_offset
    import ea_pkg::*;
#(
    parameter int GPR_N = 8,
    parameter int REG_W = 32
) (
    input  logic                        a32,
    input  logic [1:0]                  md,
    input  logic [2:0]                  rm,
    input  sib_t                        sib,
    input  logic                        has_sib,
    input  logic [2:0]                  disp_len,
    input  logic [REG_W-1:0]            disp,
    input  logic [GPR_N-1:0][REG_W-1:0] gpr,
    output logic [REG_W-1:0]            offset,
    output logic                        use_ss
);
    logic [REG_W-1:0] d_ext;
    logic [15:0]      b16, i16, sum16;
    logic [REG_W-1:0] base_t, idx_t;

    assign d_ext = sext_disp(disp, disp_len);

    always_comb begin
        b16    = '0;
        i16    = '0;
        base_t = '0;
        idx_t  = '0;
        use_ss = 1'b0;
        case (rm)
            3'd0: begin b16 = gpr[GR_BX][15:0]; i16 = gpr[GR_SI][15:0]; end
            3'd1: begin b16 = gpr[GR_BX][15:0]; i16 = gpr[GR_DI][15:0]; end
            3'd2: begin b16 = gpr[GR_BP][15:0]; i16 = gpr[GR_SI][15:0]; end
            3'd3: begin b16 = gpr[GR_BP][15:0]; i16 = gpr[GR_DI][15:0]; end
            3'd4: b16 = gpr[GR_SI][15:0];
            3'd5: b16 = gpr[GR_DI][15:0];
            3'd6: b16 = (md == 2'b00) ? 16'h0 : gpr[GR_BP][15:0];
            default: b16 = gpr[GR_BX][15:0];
        endcase
        sum16 = b16 + i16 + d_ext[15:0];
        if (!a32) begin
            offset = {{(REG_W-16){1'b0}}, sum16};
            use_ss = (rm == 3'd2) || (rm == 3'd3) || (rm == 3'd6 && md != 2'b00);
        end else begin
            if (has_sib) begin
                base_t = (sib.base == GR_BP && md == 2'b00) ? '0 : gpr[sib.base];
                idx_t  = (sib.index == GR_SP) ? '0 : (gpr[sib.index] << sib.scale);
                use_ss = (sib.base == GR_SP) || (sib.base == GR_BP && md != 2'b00);
            end else begin
                base_t = (rm == GR_BP && md == 2'b00) ? '0 : gpr[rm];
                use_ss = (rm == GR_BP) && (md != 2'b00);
            end
            offset = base_t + idx_t + d_ext;
        end
    end
endmodule

// File: rtl/ea_seg_resolve.sv
module ea_seg_resolve
    import ea_pkg::*;
#(
    parameter int SEG_N = 6,
    parameter int SEG_W = 16
) (
    input  logic                        use_ss,
    input  logic [SEG_N-1:0]            ovr,
    input  logic [SEG_N-1:0][SEG_W-1:0] segs,
    output logic [2:0]                  sel,
    output logic [SEG_W-1:0]            base,
    output logic                        multi
);
    localparam int CNT_W = $clog2(SEG_N + 1);

    logic [CNT_W-1:0] n_set;
    logic [2:0]       ovr_code;

    always_comb begin
        n_set    = '0;
        ovr_code = 3'd0;
        for (int i = 0; i < SEG_N; i++) begin
            if (ovr[i]) begin
                n_set    = n_set + 1'b1;
                ovr_code = 3'(i);
            end
        end
        multi = (n_set > 1);
        if (n_set == 1) sel = ovr_code;
        else            sel = use_ss ? SEG_SS : SEG_DS;
        base = segs[sel];
    end
endmodule

// File: rtl/modrm_ea_unit.sv
module modrm_ea_unit
    import ea_pkg::*;
#(
    parameter int GPR_N = 8,
    parameter int REG_W = 32,
    parameter int SEG_N = 6,
    parameter int SEG_W = 16,
    parameter int PA_W  = 20
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   in_valid,
    input  logic [7:0]             in_data,
    output logic                   in_ready,
    input  logic                   addr32,
    input  logic [GPR_N*REG_W-1:0] gpr_flat,
    input  logic [SEG_N*SEG_W-1:0] seg_flat,
    input  logic [SEG_N-1:0]       seg_ovr,
    output logic                   done,
    output logic [1:0]             mod_o,
    output logic [2:0]             reg_o,
    output logic [2:0]             rm_o,
    output logic                   is_mem,
    output logic [REG_W-1:0]       offset,
    output logic [2:0]             seg_sel,
    output logic [PA_W-1:0]        phys_addr,
    output logic [2:0]             nbytes,
    output logic                   err
);
    localparam int DISP_MAX = REG_W / 8;

    logic [GPR_N-1:0][REG_W-1:0] gpr_arr;
    logic [SEG_N-1:0][SEG_W-1:0] seg_arr;
    logic                        a32_q, has_sib_q;
    modrm_t                      modrm_q;
    sib_t                        sib_q;
    logic [2:0]                  disp_len_q;
    logic [REG_W-1:0]            disp_q;
    logic [REG_W-1:0]            calc_off;
    logic                        use_ss, multi;
    logic [2:0]                  rs_sel;
    logic [SEG_W-1:0]            rs_base;

    assign gpr_arr = gpr_flat;
    assign seg_arr = seg_flat;

    ea_collect #(.DISP_MAX(DISP_MAX)) u_collect (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .addr32(addr32), .emit(done), .a32_q(a32_q),
        .modrm_q(modrm_q), .sib_q(sib_q), .has_sib_q(has_sib_q),
        .disp_len_q(disp_len_q), .disp_q(disp_q)
    );

    ea_offset #(.GPR_N(GPR_N), .REG_W(REG_W)) u_offset (
        .a32(a32_q), .md(modrm_q.md), .rm(modrm_q.rm), .sib(sib_q),
        .has_sib(has_sib_q), .disp_len(disp_len_q), .disp(disp_q),
        .gpr(gpr_arr), .offset(calc_off), .use_ss(use_ss)
    );

    ea_seg_resolve #(.SEG_N(SEG_N), .SEG_W(SEG_W)) u_seg (
        .use_ss(use_ss), .ovr(seg_ovr), .segs(seg_arr),
        .sel(rs_sel), .base(rs_base), .multi(multi)
    );

    assign mod_o   = modrm_q.md;
    assign reg_o   = modrm_q.rg;
    assign rm_o    = modrm_q.rm;
    assign is_mem  = (modrm_q.md != 2'b11);
    assign offset  = is_mem ? calc_off : '0;
    assign seg_sel = is_mem ? rs_sel : SEG_DS;
    assign err     = is_mem && multi;
    assign nbytes  = 3'd1 + {2'b00, has_sib_q} + disp_len_q;

    always_comb begin
        if (is_mem && !multi)
            phys_addr = PA_W'({rs_base, 4'b0000}) + calc_off[PA_W-1:0];
        else
            phys_addr = '0;
    end
endmodule

// File: rtl/modrm_ea_chk.sv
module modrm_ea_chk #(
    parameter int REG_W = 32,
    parameter int SEG_N = 6,
    parameter int SEG_W = 16,
    parameter int PA_W  = 20
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   in_ready,
    input logic                   done,
    input logic                   is_mem,
    input logic                   err,
    input logic [2:0]             nbytes,
    input logic [SEG_N-1:0]       seg_ovr,
    input logic [2:0]             seg_sel,
    input logic [REG_W-1:0]       offset,
    input logic [PA_W-1:0]        phys_addr,
    input logic [SEG_N*SEG_W-1:0] seg_flat
);
    a_r1_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r11_no_ready_in_done: assert property (@(posedge clk) disable iff (rst)
        done |-> !in_ready);

    a_r2_reg_operand: assert property (@(posedge clk) disable iff (rst)
        (done && !is_mem) |-> (nbytes == 3'd1 && phys_addr == '0 && !err));

    a_r7_multi_err: assert property (@(posedge clk) disable iff (rst)
        (done && is_mem && $countones(seg_ovr) > 1) |-> (err && phys_addr == '0));

    a_r6_override: assert property (@(posedge clk) disable iff (rst)
        (done && is_mem && $countones(seg_ovr) == 1) |-> seg_ovr[seg_sel]);

    a_r10_phys: assert property (@(posedge clk) disable iff (rst)
        (done && is_mem && !err) |->
        (phys_addr == PA_W'({seg_flat[32'(seg_sel)*SEG_W +: SEG_W], 4'b0000}) + offset[PA_W-1:0]));
endmodule

bind modrm_ea_unit modrm_ea_chk u_chk (
    .clk(clk), .rst(rst), .in_ready(in_ready), .done(done), .is_mem(is_mem),
    .err(err), .nbytes(nbytes), .seg_ovr(seg_ovr), .seg_sel(seg_sel),
    .offset(offset), .phys_addr(phys_addr), .seg_flat(seg_flat)
);

// File: tb/modrm_ea_unit_bench.sv
module modrm_ea_unit_bench;
    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid;
    logic [7:0]   in_data;
    logic         in_ready;
    logic         addr32;
    logic [255:0] gpr_flat;
    logic [95:0]  seg_flat;
    logic [5:0]   seg_ovr;
    logic         done;
    logic [1:0]   mod_o;
    logic [2:0]   reg_o, rm_o;
    logic         is_mem;
    logic [31:0]  offset;
    logic [2:0]   seg_sel;
    logic [19:0]  phys_addr;
    logic [2:0]   nbytes;
    logic         err;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 0;
    logic [31:0] R [8];
    logic [15:0] S [6];

    always #4 clk = ~clk;

    always_comb begin
        for (int i = 0; i < 8; i++) gpr_flat[32*i +: 32] = R[i];
        for (int i = 0; i < 6; i++) seg_flat[16*i +: 16] = S[i];
    end

    modrm_ea_unit u_modrm_ea_unit (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .addr32(addr32), .gpr_flat(gpr_flat),
        .seg_flat(seg_flat), .seg_ovr(seg_ovr), .done(done), .mod_o(mod_o),
        .reg_o(reg_o), .rm_o(rm_o), .is_mem(is_mem), .offset(offset),
        .seg_sel(seg_sel), .phys_addr(phys_addr), .nbytes(nbytes), .err(err)
    );

    task automatic chk(input string what, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", what, got, exp);
        end
    endtask

    // Behavioural model of one addressing sequence; bytes little-endian in bs.
    function automatic void model(input logic [55:0] bs, input bit a32_i, input logic [5:0] ovr_i,
                                  output int nb, output bit mem, output logic [31:0] off,
                                  output int seg, output bit er, output logic [19:0] pa);
        int m, rm, p, dl, sb, cnt;
        bit ss;
        logic [7:0]  sib;
        logic [31:0] base, idx, d, t;
        m = int'(bs[7:6]); rm = int'(bs[2:0]); p = 1; dl = 0; sb = -1;
        ss = 0; base = 0; idx = 0; d = 0; sib = 0;
        if (m == 3) begin
            nb = 1; mem = 0; off = 0; seg = 3; er = 0; pa = 0;
            return;
        end
        mem = 1;
        if (!a32_i) begin
            case (rm)
                0: base = R[3] + R[6];
                1: base = R[3] + R[7];
                2: base = R[5] + R[6];
                3: base = R[5] + R[7];
                4: base = R[6];
                5: base = R[7];
                6: base = (m == 0) ? 32'h0 : R[5];
                default: base = R[3];
            endcase
            ss = (rm == 2) || (rm == 3) || (rm == 6 && m != 0);
            if (m == 1) dl = 1;
            else if (m == 2 || (m == 0 && rm == 6)) dl = 2;
        end else begin
            if (rm == 4) begin
                sib = bs[15:8]; p = 2; sb = int'(sib[2:0]);
                base = (sb == 5 && m == 0) ? 32'h0 : R[sb];
                if (sib[5:3] != 3'd4) idx = R[sib[5:3]] << sib[7:6];
                ss = (sb == 4) || (sb == 5 && m != 0);
            end else begin
                base = (m == 0 && rm == 5) ? 32'h0 : R[rm];
                ss = (rm == 5 && m != 0);
            end
            if (m == 1) dl = 1;
            else if (m == 2 || (m == 0 && ((p == 1 && rm == 5) || (p == 2 && sb == 5)))) dl = 4;
        end
        for (int i = 0; i < dl; i++) d[8*i +: 8] = bs[8*(p+i) +: 8];
        if (dl == 1) d = {{24{d[7]}}, d[7:0]};
        if (dl == 2) d = {{16{d[15]}}, d[15:0]};
        off = base + idx + d;
        if (!a32_i) off = off & 32'h0000_FFFF;
        nb = p + dl;
        seg = ss ? 2 : 3;
        er = 0;
        cnt = $countones(ovr_i);
        if (cnt > 1) er = 1;
        else if (cnt == 1) for (int i = 0; i < 6; i++) if (ovr_i[i]) seg = i;
        t = {12'h0, S[seg], 4'h0} + off;
        pa = er ? 20'h0 : t[19:0];
    endfunction

    task automatic run(input string tag, input logic [55:0] bs, input int n,
                       input bit a32_i, input logic [5:0] ovr_i, input bit gap);
        int nb, seg;
        bit mem, er;
        logic [31:0] off;
        logic [19:0] pa;
        model(bs, a32_i, ovr_i, nb, mem, off, seg, er, pa);
        addr32 = a32_i;
        seg_ovr = ovr_i;
        for (int k = 0; k < n; k++) begin
            if (gap) begin
                in_valid = 1'b0;
                in_data  = 8'hC0;
                @(posedge clk); @(negedge clk);
                chk({tag, " R11 idle cycle takes no byte"}, {31'h0, done}, 32'h0);
            end
            in_valid = 1'b1;
            in_data  = bs[8*k +: 8];
            chk({tag, " R11 ready before byte"}, {31'h0, in_ready}, 32'h1);
            @(posedge clk); @(negedge clk);
            chk({tag, " R1 done timing"}, {31'h0, done}, (k == n-1) ? 32'h1 : 32'h0);
        end
        in_valid = 1'b0;
        chk({tag, " R1 fields"}, {24'h0, mod_o, reg_o, rm_o}, {24'h0, bs[7:0]});
        chk({tag, " R2 is_mem"}, {31'h0, is_mem}, {31'h0, mem});
        chk({tag, " R3 offset"}, offset, off);
        chk({tag, " R6 seg_sel"}, {29'h0, seg_sel}, 32'(seg));
        chk({tag, " R10 phys_addr"}, {12'h0, phys_addr}, {12'h0, pa});
        chk({tag, " R7 err"}, {31'h0, err}, {31'h0, er});
        chk({tag, " R11 nbytes"}, {29'h0, nbytes}, 32'(nb));
        chk({tag, " R11 ready low in done"}, {31'h0, in_ready}, 32'h0);
        @(posedge clk); @(negedge clk);
        chk({tag, " R1 single pulse"}, {31'h0, done}, 32'h0);
    endtask

    initial begin
        #(8 * 150000);
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        R[0] = 32'h0000_1000; R[1] = 32'h8001_0000; R[2] = 32'h0000_3000; R[3] = 32'h0000_FFF0;
        R[4] = 32'h0000_8000; R[5] = 32'h0000_7000; R[6] = 32'h0000_0020; R[7] = 32'h0000_0400;
        S[0] = 16'h1000; S[1] = 16'h2000; S[2] = 16'h3000;
        S[3] = 16'h4000; S[4] = 16'h5000; S[5] = 16'hF800;
        rst = 1'b1; in_valid = 1'b0; in_data = 8'h00; addr32 = 1'b0; seg_ovr = 6'h0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk("reset R1 done low", {31'h0, done}, 32'h0);
        chk("reset R11 ready high", {31'h0, in_ready}, 32'h1);
        @(negedge clk);

        // R2 register operand, also with a multi-override (R7 no error)
        run("R2 reg", 56'hD8, 1, 1'b0, 6'h00, 1'b0);
        run("R7 reg ovr", 56'hC1, 1, 1'b1, 6'h03, 1'b0);
        // R3/R4 16-bit forms
        run("R4 bx+si wrap", 56'h00, 1, 1'b0, 6'h00, 1'b0);
        run("R3 direct", 56'h12_34_06, 3, 1'b0, 6'h00, 1'b1);
        run("R3 si no sib", 56'h04, 1, 1'b0, 6'h00, 1'b0);
        run("R5 bp+si d8neg", 56'hFE_42, 2, 1'b0, 6'h00, 1'b0);
        run("R5 bp d16", 56'h80_00_86, 3, 1'b0, 6'h00, 1'b1);
        run("R4 bx+di d16", 56'hFF_F0_81, 3, 1'b0, 6'h00, 1'b0);
        // R6 single override, R7 multiple
        run("R6 es ovr", 56'h10_43, 2, 1'b0, 6'h01, 1'b0);
        run("R7 two ovr", 56'h10_43, 2, 1'b0, 6'h22, 1'b0);
        run("R10 gs wrap", 56'h07, 1, 1'b0, 6'h20, 1'b0);
        // R8 32-bit forms
        run("R8 disp32", 56'h12_34_56_78_05, 5, 1'b1, 6'h00, 1'b0);
        run("R8 ecx d8", 56'h80_41, 2, 1'b1, 6'h00, 1'b1);
        run("R8 ebp d32", 56'h00_00_01_00_85, 5, 1'b1, 6'h00, 1'b0);
        // R9 SIB forms
        run("R9 sib scaled", 56'h8B_04, 2, 1'b1, 6'h00, 1'b0);
        run("R9 sib esp noidx", 56'h10_24_44, 3, 1'b1, 6'h00, 1'b1);
        run("R9 sib base5", 56'h00_00_20_00_F5_04, 6, 1'b1, 6'h10, 1'b0);
        run("R9 sib ebp d8", 56'hF0_7D_44, 3, 1'b1, 6'h00, 1'b0);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule